// File: doc/BRIEF.md
# Serially Programmed Configuration Select Register

This block stands in for a bank of configuration jumpers. A small configuration word of `MUX_W + 1` bits (five by default) is written by a host over a two-byte, I2C-style transaction. The serial front end is assumed to exist elsewhere, so the block sees an already-assembled byte stream: a one-cycle `bus_start` strobe, one-cycle `rx_valid` byte strobes, and a one-cycle `bus_stop` strobe.

The lower `MUX_W` configuration bits form one input of a per-bit 2:1 selector. The other input is the live `ext_in` bus, and the `sel_reg` pin chooses between them. The top configuration bit drives `solo_out` directly, without passing through the selector. That output is frozen from the moment a write to this device is accepted until the transaction ends, so a rewrite never disturbs it partway through. A write-lock pin blocks register updates, and a force pin pulls every output low for diagnostics.

A read returns the stored word through `rd_valid`/`rd_byte`, and any device address other than the configured one is ignored.

Top module: `cfg_jumper_mux`

## Requirements
- R1: After reset, the configuration word equals `RST_CFG` (default 0). With `force_low` low, `solo_out` is 0, and `mux_out` equals `ext_in` when `sel_reg` is 0 or 0 when `sel_reg` is 1.
- R2: The first byte after `bus_start` is the address byte: bits [7:1] hold the device address and bit 0 holds the direction (0 = write, 1 = read). On a write to `DEV_ADDR`, bits [MUX_W:0] of the next byte load the configuration word at the clock edge that samples that byte.
- R3: On a read of `DEV_ADDR`, `rd_valid` is high for exactly the one cycle after the edge that samples the address byte. `rd_byte` then carries the configuration word in bits [MUX_W:0], with all higher bits 0.
- R4: An address byte whose bits [7:1] differ from `DEV_ADDR` produces no register change and no `rd_valid`. Every following byte up to the next `bus_start` is also ignored.
- R5: A write transaction loads only its first data byte; any further bytes before the next `bus_start` are ignored.
- R6: While `wr_lock` is high on the edge that samples a write data byte, the configuration word keeps its value.
- R7: With `force_low` low, `mux_out[i]` is configuration bit i when `sel_reg` is 1 and `ext_in[i]` when `sel_reg` is 0. The output is combinational from these inputs.
- R8: `solo_out` shows configuration bit MUX_W. It holds its value from the edge that accepts a matching write address byte until a `bus_start` or `bus_stop` is sampled, and it takes the stored bit one edge after that release.
- R9: While `force_low` is high, `mux_out` and `solo_out` are all 0, whatever the values of `sel_reg`, `ext_in` and the register.
- R10: A byte strobe that arrives with no open transaction (after reset or after `bus_stop`) is ignored. `bus_start` takes priority over `bus_stop`, and `bus_stop` takes priority over a byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_start | input | 1 | One-cycle strobe that opens a transaction |
| bus_stop | input | 1 | One-cycle strobe that closes a transaction |
| rx_valid | input | 1 | One-cycle strobe that marks a received byte |
| rx_byte | input | 8 | Received byte, valid when `rx_valid` is high |
| wr_lock | input | 1 | Blocks register writes when high |
| force_low | input | 1 | Forces all outputs to 0 when high |
| sel_reg | input | 1 | Selector control: 1 picks register bits, 0 picks `ext_in` |
| ext_in | input | MUX_W | Live input side of the selector |
| mux_out | output | MUX_W | Selector outputs |
| solo_out | output | 1 | Output driven by the top configuration bit, held during writes |
| rd_valid | output | 1 | One-cycle strobe that marks read data |
| rd_byte | output | 8 | Read data: the configuration word, zero-extended |

## Verification
The bench targets the hold window on `solo_out`. A design that let that output follow the register at once would show the new top bit between the data byte and the stop. A design that never released the hold would keep the old value after the stop.

It also sends a wrong address followed by a byte shaped like data, a second data byte in one write, and bytes with no transaction open. A decoder that compared too few address bits, or that reopened after one byte, would then change the stored word, and a later read would expose it.

Other checks cover the write lock, a restart in the middle of a write, and `force_low` against every selector setting. A lock wired the wrong way, a priority order turned around, or a force that covered only some outputs would each produce a mismatch in the per-cycle comparison.

// File: rtl/cfgmux_pkg.sv
package cfgmux_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ADDR  = 2'd1,
    XS_WDATA = 2'd2,
    XS_SKIP  = 2'd3
  } xact_state_e;
endpackage

// File: rtl/cfgmux_xact.sv
module cfgmux_xact
  import cfgmux_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic              rd_req_o,
  output logic              busy_o
);
  xact_state_e state_q, state_d;
  logic        busy_q, busy_d;
  logic        addr_hit;
  logic        dir_read;
  logic        byte_take;

  assign addr_hit  = (byte_i[BYTE_W-1:1] == DEV_ADDR);
  assign dir_read  = byte_i[0];
  assign byte_take = vld_i && !start_i && !stop_i;

  always_comb begin
    state_d  = state_q;
    busy_d   = busy_q;
    wr_en_o  = 1'b0;
    rd_req_o = 1'b0;
    if (start_i) begin
      state_d = XS_ADDR;
      busy_d  = 1'b0;
    end else if (stop_i) begin
      state_d = XS_IDLE;
      busy_d  = 1'b0;
    end else if (byte_take) begin
      unique case (state_q)
        XS_ADDR: begin
          if (addr_hit && dir_read) begin
            rd_req_o = 1'b1;
            state_d  = XS_SKIP;
          end else if (addr_hit) begin
            busy_d  = 1'b1;
            state_d = XS_WDATA;
          end else begin
            state_d = XS_SKIP;
          end
        end
        XS_WDATA: begin
          wr_en_o = 1'b1;
          state_d = XS_SKIP;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
    end
  end

  assign busy_o = busy_q;

  // R5: a single data byte per write transaction
  a_r5_one_data_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  // R4: a foreign address closes the transaction for this device
  a_r4_foreign_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_ADDR && byte_take && !addr_hit) |=> (state_q == XS_SKIP && !busy_q));

  // R8: the hold window opens only on an accepted address byte
  a_r8_hold_opens: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(state_q) == XS_ADDR && $past(byte_take)));

  // R10: stop closes everything
  a_r10_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (state_q == XS_IDLE && !busy_q));
endmodule

// File: rtl/cfgmux_store.sv
module cfgmux_store
  import cfgmux_pkg::*;
#(
  parameter int               CFG_W   = 5,
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              lock_i,
  input  logic [CFG_W-1:0]  data_i,
  input  logic              rd_req_i,
  input  logic              busy_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              solo_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  localparam int PAD_W = BYTE_W - CFG_W;

  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              cfg_ld;
  logic              solo_q, solo_d;
  logic              solo_ld;
  logic              rdv_q;
  logic [BYTE_W-1:0] rdb_q, rdb_d;

  assign cfg_ld  = wr_en_i && !lock_i;
  assign solo_ld = !busy_i;

  always_comb begin
    cfg_d  = cfg_ld  ? data_i : cfg_q;
    solo_d = solo_ld ? cfg_q[CFG_W-1] : solo_q;
    rdb_d  = rd_req_i ? {{PAD_W{1'b0}}, cfg_q} : rdb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RST_CFG;
      solo_q <= RST_CFG[CFG_W-1];
      rdv_q  <= 1'b0;
      rdb_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      solo_q <= solo_d;
      rdv_q  <= rd_req_i;
      rdb_q  <= rdb_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign solo_o     = solo_q;
  assign rd_valid_o = rdv_q;
  assign rd_byte_o  = rdb_q;

  // R2: an unlocked data byte lands in the register on its edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !lock_i) |=> (cfg_q == $past(data_i)));

  // R6: the lock keeps the register untouched
  a_r6_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && lock_i) |=> $stable(cfg_q));

  // R8: the standalone output does not move inside the hold window
  a_r8_solo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(solo_q));

  // R3: read data reflects the register at request time
  a_r3_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> (rd_byte_o[CFG_W-1:0] == $past(cfg_q)));
endmodule

// File: rtl/cfgmux_outsel.sv
module cfgmux_outsel #(
  parameter int MUX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_i,
  input  logic             sel_i,
  input  logic [MUX_W-1:0] reg_i,
  input  logic [MUX_W-1:0] ext_i,
  input  logic             solo_i,
  output logic [MUX_W-1:0] mux_o,
  output logic             solo_o
);
  for (genvar i = 0; i < MUX_W; i++) begin : g_bit
    logic picked;
    assign picked   = sel_i ? reg_i[i] : ext_i[i];
    assign mux_o[i] = picked && !force_i;
  end

  assign solo_o = solo_i && !force_i;

  // R9: force pulls every output low
  a_r9_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |-> (mux_o == '0 && !solo_o));
endmodule

// File: rtl/cfg_jumper_mux.sv
module cfg_jumper_mux
  import cfgmux_pkg::*;
#(
  parameter int               MUX_W    = 4,
  parameter logic [6:0]       DEV_ADDR = 7'h2A,
  parameter logic [MUX_W:0]   RST_CFG  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              wr_lock,
  input  logic              force_low,
  input  logic              sel_reg,
  input  logic [MUX_W-1:0]  ext_in,
  output logic [MUX_W-1:0]  mux_out,
  output logic              solo_out,
  output logic              rd_valid,
  output logic [7:0]        rd_byte
);
  localparam int CFG_W  = MUX_W + 1;
  localparam int ADDR_W = BYTE_W - 1;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             wr_en, rd_req, busy;
  logic [CFG_W-1:0] cfg;
  logic             solo_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  cfgmux_xact #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_xact (
    .clk(clk), .rst_n(rst_int_n),
    .start_i(bus_start), .stop_i(bus_stop), .vld_i(rx_valid), .byte_i(rx_byte),
    .wr_en_o(wr_en), .rd_req_o(rd_req), .busy_o(busy)
  );

  cfgmux_store #(.CFG_W(CFG_W), .RST_CFG(RST_CFG)) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en_i(wr_en), .lock_i(wr_lock), .data_i(rx_byte[CFG_W-1:0]),
    .rd_req_i(rd_req), .busy_i(busy),
    .cfg_o(cfg), .solo_o(solo_held),
    .rd_valid_o(rd_valid), .rd_byte_o(rd_byte)
  );

  cfgmux_outsel #(.MUX_W(MUX_W)) u_outsel (
    .clk(clk), .rst_n(rst_int_n),
    .force_i(force_low), .sel_i(sel_reg),
    .reg_i(cfg[MUX_W-1:0]), .ext_i(ext_in), .solo_i(solo_held),
    .mux_o(mux_out), .solo_o(solo_out)
  );

  // R3: read data only ever follows a received byte
  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid |-> ($past(rx_valid) && !$past(bus_start) && !$past(bus_stop)));

  // R3: read strobe is a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/sim_cfg_jumper_mux.sv
module sim_cfg_jumper_mux;
  localparam logic [6:0] DEV  = 7'h2A;
  localparam logic [6:0] OTHR = 7'h2B;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_start, bus_stop, rx_valid;
  logic [7:0] rx_byte;
  logic       wr_lock, force_low, sel_reg;
  logic [3:0] ext_in;
  logic [3:0] mux_out;
  logic       solo_out, rd_valid;
  logic [7:0] rd_byte;

  always #4 clk = ~clk;

  cfg_jumper_mux #(.MUX_W(4), .DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .wr_lock(wr_lock),
    .force_low(force_low), .sel_reg(sel_reg), .ext_in(ext_in),
    .mux_out(mux_out), .solo_out(solo_out), .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference: phase 0 idle, 1 address, 2 data, 3 skip
  logic [4:0] m_cfg;
  logic       m_solo, m_busy, m_rdv;
  logic [7:0] m_rdd;
  int         m_ph;
  logic [7:0] last_rd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [4:0] c0 = m_cfg;
    logic       b0 = m_busy;
    m_rdv = 1'b0;
    if (!b0) m_solo = c0[4];
    if (bus_start) begin
      m_ph = 1; m_busy = 1'b0;
    end else if (bus_stop) begin
      m_ph = 0; m_busy = 1'b0;
    end else if (rx_valid) begin
      if (m_ph == 1) begin
        if (rx_byte[7:1] != DEV) m_ph = 3;
        else if (rx_byte[0]) begin
          m_rdv = 1'b1; m_rdd = {3'b000, c0}; m_ph = 3;
        end else begin
          m_ph = 2; m_busy = 1'b1;
        end
      end else if (m_ph == 2) begin
        if (!wr_lock) m_cfg = rx_byte[4:0];
        m_ph = 3;
      end
    end
  endtask

  task automatic compare();
    logic [3:0] em;
    logic       es;
    em = force_low ? 4'h0 : (sel_reg ? m_cfg[3:0] : ext_in);
    es = force_low ? 1'b0 : m_solo;
    chk(force_low ? "R9 mux forced" : (sel_reg ? "R7 mux reg side" : "R7 mux ext side"),
        32'(mux_out), 32'(em));
    chk(force_low ? "R9 solo forced" : "R8 solo", 32'(solo_out), 32'(es));
    chk("R3 rd_valid", 32'(rd_valid), 32'(m_rdv));
    if (m_rdv) chk("R3 rd_byte", 32'(rd_byte), 32'(m_rdd));
    if (rd_valid) last_rd = rd_byte;
  endtask

  task automatic step(bit s, bit p, bit v, logic [7:0] b);
    bus_start = s; bus_stop = p; rx_valid = v; rx_byte = b;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00);
  endtask

  task automatic do_write(logic [6:0] a, logic [7:0] d);
    step(1, 0, 0, 8'h00);
    step(0, 0, 1, {a, 1'b0});
    step(0, 0, 1, d);
    idle(1);
    step(0, 1, 0, 8'h00);
    idle(2);
  endtask

  task automatic do_read(logic [6:0] a);
    last_rd = 8'hEE;
    step(1, 0, 0, 8'h00);
    step(0, 0, 1, {a, 1'b1});
    idle(1);
    step(0, 1, 0, 8'h00);
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_start = 0; bus_stop = 0; rx_valid = 0; rx_byte = 0;
    wr_lock = 0; force_low = 0; sel_reg = 0; ext_in = 4'h9;
    m_cfg = 5'h00; m_solo = 0; m_busy = 0; m_rdv = 0; m_rdd = 0; m_ph = 0; last_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    chk("R1 ext passes", 32'(mux_out), 32'h9);
    chk("R1 solo low", 32'(solo_out), 32'h0);
    sel_reg = 1'b1; #1;
    chk("R1 reg side zero", 32'(mux_out), 32'h0);

    // R10: bytes with no open transaction
    step(0, 0, 1, {DEV, 1'b0});
    step(0, 0, 1, 8'h1F);
    idle(2);
    chk("R10 no load without start", 32'(mux_out), 32'h0);

    // R2 and R8: write 0x15, observe hold then release
    step(1, 0, 0, 8'h00);
    step(0, 0, 1, {DEV, 1'b0});
    step(0, 0, 1, 8'h15);
    chk("R2 load visible", 32'(mux_out), 32'h5);
    idle(2);
    chk("R8 solo held during write", 32'(solo_out), 32'h0);
    step(0, 1, 0, 8'h00);
    chk("R8 still held on release edge", 32'(solo_out), 32'h0);
    idle(1);
    chk("R8 solo after release", 32'(solo_out), 32'h1);

    // R3: read back with zero padding
    do_read(DEV);
    chk("R3 read value", 32'(last_rd), 32'h15);

    // R4: foreign address followed by a data-shaped byte
    do_write(OTHR, 8'h0A);
    step(1, 0, 0, 8'h00);
    step(0, 0, 1, {OTHR, 1'b1});
    step(0, 0, 1, 8'h03);
    idle(1);
    step(0, 1, 0, 8'h00);
    chk("R4 no read strobe", 32'(rd_valid), 32'h0);
    do_read(DEV);
    chk("R4 foreign ignored", 32'(last_rd), 32'h15);

    // R6: write lock
    wr_lock = 1'b1;
    do_write(DEV, 8'h0A);
    wr_lock = 1'b0;
    do_read(DEV);
    chk("R6 locked write ignored", 32'(last_rd), 32'h15);

    // R5: extra data bytes
    step(1, 0, 0, 8'h00);
    step(0, 0, 1, {DEV, 1'b0});
    step(0, 0, 1, 8'h03);
    step(0, 0, 1, 8'h1C);
    step(0, 0, 1, 8'h1F);
    step(0, 1, 0, 8'h00);
    idle(2);
    do_read(DEV);
    chk("R5 first byte only", 32'(last_rd), 32'h03);
    chk("R8 solo follows cleared bit", 32'(solo_out), 32'h0);

    // R10: priority of start over stop and byte, stop over byte
    step(1, 1, 1, {DEV, 1'b0});
    step(0, 0, 1, {DEV, 1'b0});
    step(0, 1, 1, 8'h1E);
    idle(2);
    do_read(DEV);
    chk("R10 stop beats byte", 32'(last_rd), 32'h03);

    // R8: restart in the middle of a write releases the hold
    step(1, 0, 0, 8'h00);
    step(0, 0, 1, {DEV, 1'b0});
    step(0, 0, 1, 8'h1C);
    step(1, 0, 0, 8'h00);
    idle(1);
    chk("R8 restart releases", 32'(solo_out), 32'h1);
    step(0, 1, 0, 8'h00);

    // R7 and R9: selector and force under many patterns
    for (int k = 0; k < 16; k++) begin
      ext_in    = 4'(k * 7 + 3);
      sel_reg   = k[0];
      force_low = k[1] ^ k[3];
      idle(1);
    end
    force_low = 1'b1; sel_reg = 1'b1; ext_in = 4'hF;
    idle(1);
    chk("R9 all low", 32'({mux_out, solo_out}), 32'h0);
    force_low = 1'b0; sel_reg = 1'b0;
    idle(1);
    chk("R7 ext side", 32'(mux_out), 32'hF);
    sel_reg = 1'b1;
    idle(1);
    chk("R7 reg side", 32'(mux_out), 32'hC);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule